// File: doc/BRIEF.md
# Hibernate Wakeup and Reset Sequencer

This block steps a chip into a low-power hibernate state and back out again. Time is counted in milliseconds of a slow always-on clock. A fixed number of clock cycles makes one millisecond, set by a parameter. Software asks for power-down by writing a request bit. While the chip sleeps, the block watches two wake sources. One is an external wake pin, which must stay high for a programmable filter time. The other is the real-time-clock alarm, which counts only when alarm wakeup is enabled.

Once a wake is accepted, the block drives the system reset low for a programmable number of milliseconds. When it releases the reset, it records why the chip woke and why it was reset in a sticky status word. An external reset request made while the chip is awake runs through the same reset stretch. A 32-bit scratch word is kept across hibernation, so firmware can leave a validity marker in it.

Register writes use a single-cycle strobe with a 3-bit selector. Reads are combinational through a separate selector. The selector codes are: 0 control, 1 filter time, 2 reset duration, 3 wake enable, 4 status, 5 scratch. Any other code reads as zero. Below, T stands for the parameter TICKS_PER_MS.

Top module: `hib_seq`

## Requirements
- R1: After reset the block is awake: `pwr_down`=0, `sys_rst_n`=1, `scratch_valid`=0, and every register reads 0.
- R2: Writing selector 0 with bit 0 set while awake sets `pwr_down` from the next cycle. Reading selector 0 returns `pwr_down` in bit 0.
- R3: A write to selector 1 takes the value as milliseconds and clamps it to 2047. It reads back at bits 15:5.
- R4: A write to selector 2 takes the value as milliseconds and clamps it to 127. It reads back at bits 11:5.
- R5: The wake pin passes through a two-stage synchronizer. A pin wake needs the synchronized pin to stay high for more than N·T consecutive cycles, where N is the filter time. Any low sample returns the block to hibernate, and the count restarts. The first `sys_rst_n` low is seen at the 4+N·T-th clock edge after the pin rises.
- R6: In hibernate, `rtc_alarm` high wakes the block on the next edge only when bit 0 of selector 3 is set. Otherwise the alarm has no effect.
- R7: After a wake, `sys_rst_n` is low for exactly M·T+1 cycles, where M is the reset duration. The block is then awake again. `pwr_down` and a low `sys_rst_n` never occur together.
- R8: Status (selector 4) is updated when the reset is released. The bits are: bit 0 alarm wake, bit 1 pin wake, bit 4 external reset, bit 5 reset that followed hibernation.
- R9: A write to the status register keeps only the bits that are 1 in the written data. Writing zero clears every status bit.
- R10: The scratch word (selector 5) changes only when written, including across a hibernate and wake cycle. `scratch_valid` is 1 exactly when it holds 0x52544356.
- R11: `ext_rst_req` high while awake starts the reset stretch and records status bit 4. With a reset duration of 0, `sys_rst_n` is low for a single cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Slow always-on clock |
| rst_n | input | 1 | Synchronous active-low power-on reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 3 | Register selector for writes |
| wr_data | input | 32 | Write data |
| rd_sel | input | 3 | Register selector for reads |
| rd_data | output | 32 | Read data, combinational |
| wake_pin | input | 1 | Asynchronous wake pin, active high |
| rtc_alarm | input | 1 | Alarm from the real-time clock, synchronous |
| ext_rst_req | input | 1 | External reset request, synchronous |
| pwr_down | output | 1 | High while hibernating or filtering the pin |
| sys_rst_n | output | 1 | Stretched system reset, active low |
| scratch_valid | output | 1 | Scratch word holds the validity marker |

## Verification
The assertions assume that `rtc_alarm`, `ext_rst_req` and the write port are already synchronous to `clk`. They also assume that a power-down request is never made in the same cycle as an external reset request, because the external reset wins. The bench drives every input on the falling edge and only ever makes one of these requests at a time. The wake pin is the only asynchronous input. The bench holds each pin level for whole cycles, so the synchronizer delay in R5 can be counted exactly.

// File: rtl/hib_pkg.sv
// Shared constants and types for the hibernate sequencer.
// Assumes: one write and one read selector space of eight codes.
package hib_pkg;
    typedef enum logic [1:0] {
        ST_ACTIVE = 2'd0,
        ST_HIB    = 2'd1,
        ST_FILTER = 2'd2,
        ST_RESET  = 2'd3
    } hib_state_e;

    localparam logic [2:0] SEL_CTL  = 3'd0;
    localparam logic [2:0] SEL_FILT = 3'd1;
    localparam logic [2:0] SEL_RDUR = 3'd2;
    localparam logic [2:0] SEL_WAKE = 3'd3;
    localparam logic [2:0] SEL_STAT = 3'd4;
    localparam logic [2:0] SEL_SCR  = 3'd5;

    localparam int FILT_W  = 11;
    localparam int RDUR_W  = 7;
    localparam int FIELD_LSB = 5;
    localparam int STAT_W  = 6;

    localparam int CAUSE_ALM = 0;
    localparam int CAUSE_PIN = 1;
    localparam int CAUSE_EXT = 4;
    localparam int CAUSE_HIB = 5;

    localparam logic [31:0] VALID_MARK = 32'h5254_4356;
endpackage

// File: rtl/hib_sync.sv
// Multi-stage synchronizer for one asynchronous level.
// Assumes: input changes slower than one clock period.
module hib_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_async,
    output logic q_sync
);
    logic [STAGES-1:0] chain;

    // Shift the input through the flop chain.
    always_ff @(posedge clk) begin
        if (!rst_n) chain <= '0;
        else        chain <= {chain[STAGES-2:0], d_async};
    end

    assign q_sync = chain[STAGES-1];
endmodule

// File: rtl/hib_regs.sv
// Register file: clamped timing fields, wake enable, sticky status, scratch.
// Assumes: commit pulses one cycle when the reset stretch ends.
module hib_regs
    import hib_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [2:0]        wr_sel,
    input  logic [31:0]       wr_data,
    input  logic [2:0]        rd_sel,
    input  logic              pwr_down,
    input  logic              commit,
    input  logic [STAT_W-1:0] cause,
    output logic [31:0]       rd_data,
    output logic [FILT_W-1:0] filt_ms,
    output logic [RDUR_W-1:0] rdur_ms,
    output logic              alarm_en,
    output logic [STAT_W-1:0] status,
    output logic [31:0]       scratch
);
    localparam logic [FILT_W-1:0] FILT_MAX = '1;
    localparam logic [RDUR_W-1:0] RDUR_MAX = '1;

    logic [FILT_W-1:0] filt_clamp;
    logic [RDUR_W-1:0] rdur_clamp;
    logic [STAT_W-1:0] stat_kept;

    // Clamp incoming millisecond values to their field maxima.
    always_comb begin
        filt_clamp = (|wr_data[31:FILT_W]) ? FILT_MAX : wr_data[FILT_W-1:0];
        rdur_clamp = (|wr_data[31:RDUR_W]) ? RDUR_MAX : wr_data[RDUR_W-1:0];
        stat_kept  = (wr_en && wr_sel == SEL_STAT) ? (status & wr_data[STAT_W-1:0]) : status;
    end

    // Hold the programmable fields and the scratch word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            filt_ms  <= '0;
            rdur_ms  <= '0;
            alarm_en <= 1'b0;
            scratch  <= '0;
        end else if (wr_en) begin
            if (wr_sel == SEL_FILT) filt_ms  <= filt_clamp;
            if (wr_sel == SEL_RDUR) rdur_ms  <= rdur_clamp;
            if (wr_sel == SEL_WAKE) alarm_en <= wr_data[0];
            if (wr_sel == SEL_SCR)  scratch  <= wr_data;
        end
    end

    // Sticky status: masked by writes, causes merged at reset release.
    always_ff @(posedge clk) begin
        if (!rst_n) status <= '0;
        else        status <= stat_kept | (commit ? cause : '0);
    end

    // Combinational read mux.
    always_comb begin
        rd_data = '0;
        case (rd_sel)
            SEL_CTL:  rd_data[0] = pwr_down;
            SEL_FILT: rd_data[FIELD_LSB +: FILT_W] = filt_ms;
            SEL_RDUR: rd_data[FIELD_LSB +: RDUR_W] = rdur_ms;
            SEL_WAKE: rd_data[0] = alarm_en;
            SEL_STAT: rd_data[STAT_W-1:0] = status;
            SEL_SCR:  rd_data = scratch;
            default:  rd_data = '0;
        endcase
    end
endmodule

// File: rtl/hib_fsm.sv
// Sequencer: active, hibernate, pin filter, reset stretch.
// Assumes: pin_s is synchronized; alarm and ext_req are synchronous.
module hib_fsm
    import hib_pkg::*;
#(
    parameter int TICKS_PER_MS = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pin_s,
    input  logic              alarm,
    input  logic              alarm_en,
    input  logic              pdn_req,
    input  logic              ext_req,
    input  logic [FILT_W-1:0] filt_ms,
    input  logic [RDUR_W-1:0] rdur_ms,
    output hib_state_e        state,
    output logic [STAT_W-1:0] cause,
    output logic              commit
);
    localparam int CNT_W = $clog2(((1 << FILT_W) - 1) * TICKS_PER_MS + 1);

    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] filt_tgt;
    logic [CNT_W-1:0] rst_tgt;

    // Millisecond targets converted to cycle counts.
    always_comb begin
        filt_tgt = CNT_W'(filt_ms) * CNT_W'(TICKS_PER_MS);
        rst_tgt  = CNT_W'(rdur_ms) * CNT_W'(TICKS_PER_MS);
        commit   = (state == ST_RESET) && (cnt >= rst_tgt);
    end

    // State transitions, shared cycle counter and cause capture.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_ACTIVE;
            cnt   <= '0;
            cause <= '0;
        end else begin
            case (state)
                ST_ACTIVE: begin
                    cnt <= '0;
                    if (ext_req) begin
                        state <= ST_RESET;
                        cause <= STAT_W'(1) << CAUSE_EXT;
                    end else if (pdn_req) begin
                        state <= ST_HIB;
                    end
                end
                ST_HIB: begin
                    cnt <= '0;
                    if (alarm && alarm_en) begin
                        state <= ST_RESET;
                        cause <= (STAT_W'(1) << CAUSE_ALM) | (STAT_W'(1) << CAUSE_HIB);
                    end else if (pin_s) begin
                        state <= ST_FILTER;
                    end
                end
                ST_FILTER: begin
                    if (!pin_s) begin
                        state <= ST_HIB;
                        cnt   <= '0;
                    end else if (cnt >= filt_tgt) begin
                        state <= ST_RESET;
                        cnt   <= '0;
                        cause <= (STAT_W'(1) << CAUSE_PIN) | (STAT_W'(1) << CAUSE_HIB);
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                default: begin
                    if (cnt >= rst_tgt) begin
                        state <= ST_ACTIVE;
                        cnt   <= '0;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
            endcase
        end
    end
endmodule

// File: rtl/hib_seq.sv
// Top: hibernate wakeup and reset sequencer.
// Assumes: clk is the slow always-on clock, TICKS_PER_MS cycles per ms.
module hib_seq
    import hib_pkg::*;
#(
    parameter int TICKS_PER_MS = 32,
    parameter int SYNC_STAGES  = 2
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_en,
    input  logic [2:0]  wr_sel,
    input  logic [31:0] wr_data,
    input  logic [2:0]  rd_sel,
    output logic [31:0] rd_data,
    input  logic        wake_pin,
    input  logic        rtc_alarm,
    input  logic        ext_rst_req,
    output logic        pwr_down,
    output logic        sys_rst_n,
    output logic        scratch_valid
);
    hib_state_e        state;
    logic              pin_s;
    logic              alarm_en;
    logic              commit;
    logic              pdn_req;
    logic [STAT_W-1:0] cause;
    logic [STAT_W-1:0] status;
    logic [FILT_W-1:0] filt_ms;
    logic [RDUR_W-1:0] rdur_ms;
    logic [31:0]       scratch;

    // Decode the power-down request and the state-driven outputs.
    always_comb begin
        pdn_req       = wr_en && (wr_sel == SEL_CTL) && wr_data[0];
        pwr_down      = (state == ST_HIB) || (state == ST_FILTER);
        sys_rst_n     = (state != ST_RESET);
        scratch_valid = (scratch == VALID_MARK);
    end

    hib_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .d_async (wake_pin),
        .q_sync  (pin_s)
    );

    hib_regs u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_sel   (wr_sel),
        .wr_data  (wr_data),
        .rd_sel   (rd_sel),
        .pwr_down (pwr_down),
        .commit   (commit),
        .cause    (cause),
        .rd_data  (rd_data),
        .filt_ms  (filt_ms),
        .rdur_ms  (rdur_ms),
        .alarm_en (alarm_en),
        .status   (status),
        .scratch  (scratch)
    );

    hib_fsm #(.TICKS_PER_MS(TICKS_PER_MS)) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .pin_s    (pin_s),
        .alarm    (rtc_alarm),
        .alarm_en (alarm_en),
        .pdn_req  (pdn_req),
        .ext_req  (ext_rst_req),
        .filt_ms  (filt_ms),
        .rdur_ms  (rdur_ms),
        .state    (state),
        .cause    (cause),
        .commit   (commit)
    );
endmodule

// File: rtl/hib_seq_chk.sv
// Checker for hib_seq, attached by bind.
// Assumes: the inputs named in the brief are synchronous to clk.
module hib_seq_chk
    import hib_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic [2:0]        wr_sel,
    input logic [31:0]       wr_data,
    input logic              ext_rst_req,
    input logic              rtc_alarm,
    input logic              pwr_down,
    input logic              sys_rst_n,
    input hib_state_e        state,
    input logic              pin_s,
    input logic              alarm_en,
    input logic [STAT_W-1:0] status,
    input logic [31:0]       scratch
);
    // R2: a power-down request while awake takes effect next cycle.
    a_r2_pdn_enters: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_sel == SEL_CTL && wr_data[0] && state == ST_ACTIVE && !ext_rst_req)
        |=> pwr_down);

    // R7: the chip is never asleep and held in reset at once.
    a_r7_no_pdn_in_reset: assert property (@(posedge clk) disable iff (!rst_n)
        !(pwr_down && !sys_rst_n));

    // R5: a low synchronized pin aborts filtering.
    a_r5_filter_abort: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_FILTER && !pin_s) |=> state == ST_HIB);

    // R6: with alarm wakeup disabled and the pin low, hibernate persists.
    a_r6_alarm_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_HIB && !alarm_en && !pin_s) |=> state == ST_HIB);

    // R8: status moves only on a write or at the end of the reset stretch.
    a_r8_status_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (!(wr_en && wr_sel == SEL_STAT) && state != ST_RESET) |=> $stable(status));

    // R10: scratch changes only when written.
    a_r10_scratch_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && wr_sel == SEL_SCR) |=> $stable(scratch));

    // R6: an alarm ignored while disabled leaves the block asleep.
    a_r6_alarm_no_reset: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_HIB && rtc_alarm && !alarm_en) |=> sys_rst_n);
endmodule

bind hib_seq hib_seq_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr_en       (wr_en),
    .wr_sel      (wr_sel),
    .wr_data     (wr_data),
    .ext_rst_req (ext_rst_req),
    .rtc_alarm   (rtc_alarm),
    .pwr_down    (pwr_down),
    .sys_rst_n   (sys_rst_n),
    .state       (state),
    .pin_s       (pin_s),
    .alarm_en    (alarm_en),
    .status      (status),
    .scratch     (scratch)
);

// File: tb/hib_seq_tb.sv
module hib_seq_tb;
    localparam int CLK_PERIOD = 10;
    localparam int TPM        = 4;
    localparam int FILT_N     = 3;
    localparam int RDUR_M     = 2;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_sel = '0;
    logic [31:0] wr_data = '0;
    logic [2:0]  rd_sel = '0;
    logic [31:0] rd_data;
    logic        wake_pin = 1'b0;
    logic        rtc_alarm = 1'b0;
    logic        ext_rst_req = 1'b0;
    logic        pwr_down;
    logic        sys_rst_n;
    logic        scratch_valid;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    hib_seq #(.TICKS_PER_MS(TPM)) u_dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
        .rd_sel(rd_sel), .rd_data(rd_data), .wake_pin(wake_pin), .rtc_alarm(rtc_alarm),
        .ext_rst_req(ext_rst_req), .pwr_down(pwr_down), .sys_rst_n(sys_rst_n),
        .scratch_valid(scratch_valid)
    );

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] sel, input logic [31:0] data);
        @(negedge clk);
        wr_en = 1'b1; wr_sel = sel; wr_data = data;
        @(negedge clk);
        wr_en = 1'b0; wr_data = '0;
    endtask

    task automatic rd(input logic [2:0] sel, output logic [31:0] data);
        rd_sel = sel;
        #1;
        data = rd_data;
    endtask

    // Count cycles of the reset stretch already begun.
    task automatic count_low(output int n);
        n = 0;
        while (!sys_rst_n && n < 2000) begin
            n++;
            @(negedge clk);
        end
    endtask

    task automatic t_reset_state;
        logic [31:0] v;
        check(pwr_down == 1'b0 && sys_rst_n == 1'b1, "R1 outputs", {30'b0, pwr_down, sys_rst_n}, 32'h1);
        check(scratch_valid == 1'b0, "R1 scratch_valid", {31'b0, scratch_valid}, 32'h0);
        for (int s = 0; s < 6; s++) begin
            rd(3'(s), v);
            check(v == 32'h0, "R1 register zero", v, 32'h0);
        end
    endtask

    task automatic t_saturate;
        logic [31:0] v;
        wr(3'd1, 32'd5000);
        rd(3'd1, v);
        check(v == 32'h0000_FFE0, "R3 filter clamp", v, 32'h0000_FFE0);
        wr(3'd2, 32'd300);
        rd(3'd2, v);
        check(v == 32'h0000_0FE0, "R4 duration clamp", v, 32'h0000_0FE0);
        wr(3'd1, FILT_N);
        rd(3'd1, v);
        check(v == (FILT_N << 5), "R3 filter value", v, FILT_N << 5);
        wr(3'd2, RDUR_M);
        rd(3'd2, v);
        check(v == (RDUR_M << 5), "R4 duration value", v, RDUR_M << 5);
    endtask

    task automatic t_scratch;
        logic [31:0] v;
        wr(3'd5, 32'h1234_5678);
        check(scratch_valid == 1'b0, "R10 not marker", {31'b0, scratch_valid}, 0);
        wr(3'd5, 32'h5254_4356);
        rd(3'd5, v);
        check(v == 32'h5254_4356, "R10 readback", v, 32'h5254_4356);
        check(scratch_valid == 1'b1, "R10 marker valid", {31'b0, scratch_valid}, 1);
    endtask

    task automatic enter_hib;
        logic [31:0] v;
        wr(3'd0, 32'h1);
        check(pwr_down == 1'b1, "R2 pwr_down set", {31'b0, pwr_down}, 1);
        rd(3'd0, v);
        check(v == 32'h1, "R2 control readback", v, 1);
    endtask

    task automatic t_pin_wake;
        logic [31:0] v;
        int n;
        enter_hib();
        // Pulse held exactly N*T cycles: too short.
        @(negedge clk);
        wake_pin = 1'b1;
        repeat (FILT_N*TPM) @(negedge clk);
        wake_pin = 1'b0;
        repeat (6) @(negedge clk);
        check(pwr_down == 1'b1 && sys_rst_n == 1'b1, "R5 short pulse ignored",
              {30'b0, pwr_down, sys_rst_n}, 32'h3);
        // Held long enough.
        wake_pin = 1'b1;
        n = 0;
        while (sys_rst_n && n < 500) begin
            @(negedge clk);
            n++;
        end
        check(n == 4 + FILT_N*TPM, "R5 pin wake latency", n, 4 + FILT_N*TPM);
        check(pwr_down == 1'b0, "R7 pwr_down off in reset", {31'b0, pwr_down}, 0);
        count_low(n);
        wake_pin = 1'b0;
        check(n == RDUR_M*TPM + 1, "R7 reset length", n, RDUR_M*TPM + 1);
        rd(3'd4, v);
        check(v == 32'h22, "R8 pin status", v, 32'h22);
        check(scratch_valid == 1'b1, "R10 kept over hibernate", {31'b0, scratch_valid}, 1);
    endtask

    task automatic t_status_clear;
        logic [31:0] v;
        wr(3'd4, 32'h20);
        rd(3'd4, v);
        check(v == 32'h20, "R9 masked keep", v, 32'h20);
        wr(3'd4, 32'h0);
        rd(3'd4, v);
        check(v == 32'h0, "R9 clear all", v, 0);
    endtask

    task automatic t_alarm;
        logic [31:0] v;
        int n;
        enter_hib();
        @(negedge clk);
        rtc_alarm = 1'b1;
        repeat (3) @(negedge clk);
        check(pwr_down == 1'b1 && sys_rst_n == 1'b1, "R6 alarm disabled ignored",
              {30'b0, pwr_down, sys_rst_n}, 32'h3);
        rtc_alarm = 1'b0;
        wr(3'd3, 32'h1);
        check(pwr_down == 1'b1, "R6 still asleep", {31'b0, pwr_down}, 1);
        rtc_alarm = 1'b1;
        @(negedge clk);
        rtc_alarm = 1'b0;
        check(sys_rst_n == 1'b0, "R6 alarm wake", {31'b0, sys_rst_n}, 0);
        count_low(n);
        check(n == RDUR_M*TPM + 1, "R7 reset length alarm", n, RDUR_M*TPM + 1);
        rd(3'd4, v);
        check(v == 32'h21, "R8 alarm status", v, 32'h21);
    endtask

    task automatic t_ext_reset;
        logic [31:0] v;
        int n;
        wr(3'd2, 32'd0);
        @(negedge clk);
        ext_rst_req = 1'b1;
        @(negedge clk);
        ext_rst_req = 1'b0;
        check(sys_rst_n == 1'b0, "R11 ext reset starts", {31'b0, sys_rst_n}, 0);
        count_low(n);
        check(n == 1, "R11 zero duration one cycle", n, 1);
        rd(3'd4, v);
        check(v == 32'h31, "R11 ext status bit", v, 32'h31);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset_state();
        t_saturate();
        t_scratch();
        t_pin_wake();
        t_status_clear();
        t_alarm();
        t_ext_reset();
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end
endmodule